// File: doc/BRIEF.md
# Single-Channel Quadword DMA Engine

This block is one DMA channel that moves a block of 128-bit quadwords from a source address in memory to a destination. The destination address is a fixed base, set by a parameter, plus a target offset register. Software programs the quadword count, the source address and the target offset through a small register port. It then writes the control register with the run bit set. The engine reads one quadword over its 128-bit memory master port and writes it back out. It repeats this until the count reaches zero.

The master port uses a request/grant handshake. A request and its address, direction and write data stay stable until the grant arrives. For a read, the data is taken in the cycle the grant is seen. When the block finishes, the run bit drops and a bit in the interrupt status register is set. The interrupt output is the OR of the status bits. Writing a 1 to a status bit clears it.

Top module: `qdma_channel`

## Requirements
- R1: After reset, every register reads zero, no memory request is made and the interrupt output is low. The register indices are 0 count, 1 source address, 2 target offset, 3 control and 4 status.
- R2: A start with count N performs N read/write pairs, in order. Pair i reads from source+16·i and writes the same 128-bit data to DST_BASE+target+16·i.
- R3: A memory request keeps its address, direction and write data unchanged until the grant arrives.
- R4: Control bit 8 is the run bit. It reads 1 from the cycle after a start until the last write is granted, and 0 after that.
- R5: On completion the count reads 0, and the source and target registers have each advanced by 16·N. Each granted write lowers the count by exactly one.
- R6: Completion sets status bit 2 (register 4), and the interrupt output then goes high. Writing that bit as 1 clears it and drops the interrupt.
- R7: A start with count 0 makes no memory access. It sets status bit 2 on the same clock edge as the control write, and the run bit stays 0.
- R8: While the run bit is set, writes to the count, source or target registers have no effect.
- R9: Writing control with bit 8 clear while running stops the channel. No further request is made and no completion status is set. The count keeps the number of quadwords left to move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the quadword |
| mem_wdata | output | 128 | Write data |
| mem_gnt | input | 1 | Grant; ends the current access |
| mem_rdata | input | 128 | Read data, valid while a read is granted |
| dma_irq | output | 1 | OR of the interrupt status bits |

## Verification
The assertions check the cycle-level rules on every cycle. A request must stay stable while it waits for a grant. Each granted write must lower the count by one. A count write made while busy must be dropped. After a stop write the request must fall. A zero-count start must end at once. When the run bit falls without a stop, the interrupt must follow. The bench scenarios cover the rest: the full data path from source pattern to destination log, the final address values, the status clear, and the partial count left after a stop. They run under a steady grant and under grants spaced several cycles apart.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] IDX_COUNT = 3'd0;
  localparam logic [REG_AW-1:0] IDX_SRC   = 3'd1;
  localparam logic [REG_AW-1:0] IDX_TGT   = 3'd2;
  localparam logic [REG_AW-1:0] IDX_CTRL  = 3'd3;
  localparam logic [REG_AW-1:0] IDX_STAT  = 3'd4;
  localparam int RUN_BIT  = 8;
  localparam int DONE_BIT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2
  } qdma_state_e;
endpackage

// File: rtl/qdma_rst_sync.sv
module qdma_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/qdma_seq.sv
module qdma_seq
  import qdma_pkg::*;
#(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic          stop_wr,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  output qdma_state_e   state_q,
  output logic [DW-1:0] buf_q,
  output logic          done
);
  qdma_state_e state_d;
  logic        buf_en;

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    buf_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_wr) begin
          if (cnt_zero) done = 1'b1;
          else          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (stop_wr) state_d = ST_IDLE;
        else if (mem_gnt) begin
          buf_en  = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (stop_wr) state_d = ST_IDLE;
        else if (mem_gnt) begin
          if (cnt_last) begin
            state_d = ST_IDLE;
            done    = 1'b1;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= mem_rdata;
  end
endmodule

// File: rtl/qdma_addr_regs.sv
module qdma_addr_regs
  import qdma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int STEP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              advance,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [CW-1:0]     cnt_q,
  output logic [AW-1:0]     src_q,
  output logic [AW-1:0]     tgt_q
);
  logic [CW-1:0] cnt_d;
  logic [AW-1:0] src_d, tgt_d;
  logic          cfg_wr;

  assign cfg_wr = reg_we && !busy;

  always_comb begin
    cnt_d = cnt_q;
    src_d = src_q;
    tgt_d = tgt_q;
    if (advance) begin
      cnt_d = cnt_q - CW'(1);
      src_d = src_q + AW'(STEP);
      tgt_d = tgt_q + AW'(STEP);
    end else if (cfg_wr) begin
      if (reg_addr == IDX_COUNT) cnt_d = reg_wdata[CW-1:0];
      if (reg_addr == IDX_SRC)   src_d = reg_wdata;
      if (reg_addr == IDX_TGT)   tgt_d = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= '0;
      tgt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      src_q <= src_d;
      tgt_q <= tgt_d;
    end
  end
endmodule

// File: rtl/qdma_status.sv
module qdma_status
  import qdma_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          clr_wr,
  input  logic [SW-1:0] clr_mask,
  output logic [SW-1:0] sts_q,
  output logic          irq
);
  logic [SW-1:0] sts_d;
  logic [SW-1:0] set_vec;

  assign set_vec = done ? (SW'(1) << DONE_BIT) : '0;

  always_comb begin
    sts_d = sts_q;
    if (clr_wr) sts_d = sts_d & ~clr_mask;
    sts_d = sts_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign irq = |sts_q;
endmodule

// File: rtl/qdma_channel.sv
module qdma_channel
  import qdma_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 128,
  parameter int            CW       = 16,
  parameter int            SW       = 16,
  parameter logic [AW-1:0] DST_BASE = 32'h5000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic              dma_irq
);
  localparam int STEP = DW / 8;

  logic          rst_n_s;
  qdma_state_e   state_q;
  logic          busy, ctrl_wr, start_wr, stop_wr, done, advance;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, tgt_q;
  logic [SW-1:0] sts_q;

  qdma_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  assign busy     = (state_q != ST_IDLE);
  assign ctrl_wr  = reg_we && (reg_addr == IDX_CTRL);
  assign start_wr = ctrl_wr && reg_wdata[RUN_BIT];
  assign stop_wr  = ctrl_wr && !reg_wdata[RUN_BIT];
  assign advance  = (state_q == ST_WRITE) && mem_gnt;

  qdma_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start_wr(start_wr), .stop_wr(stop_wr),
    .cnt_zero(cnt_q == '0), .cnt_last(cnt_q == CW'(1)), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .state_q(state_q), .buf_q(mem_wdata), .done(done)
  );

  qdma_addr_regs #(.AW(AW), .CW(CW), .STEP(STEP)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .busy(busy), .advance(advance),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata[AW-1:0]),
    .cnt_q(cnt_q), .src_q(src_q), .tgt_q(tgt_q)
  );

  qdma_status #(.SW(SW)) u_sts (
    .clk(clk), .rst_n(rst_n_s), .done(done),
    .clr_wr(reg_we && (reg_addr == IDX_STAT)), .clr_mask(reg_wdata[SW-1:0]),
    .sts_q(sts_q), .irq(dma_irq)
  );

  assign mem_req  = busy;
  assign mem_we   = (state_q == ST_WRITE);
  assign mem_addr = mem_we ? (DST_BASE + tgt_q) : src_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      IDX_COUNT: reg_rdata = 32'(cnt_q);
      IDX_SRC:   reg_rdata = 32'(src_q);
      IDX_TGT:   reg_rdata = 32'(tgt_q);
      IDX_CTRL:  reg_rdata = 32'(busy) << RUN_BIT;
      IDX_STAT:  reg_rdata = 32'(sts_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qdma_channel_chk.sv
module qdma_channel_chk
  import qdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 128,
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic              mem_gnt,
  input logic              busy,
  input logic [CW-1:0]     cnt_q,
  input logic              dma_irq
);
  logic ctl_w, stop_w, start_w;
  assign ctl_w   = reg_we && (reg_addr == IDX_CTRL);
  assign stop_w  = ctl_w && !reg_wdata[RUN_BIT];
  assign start_w = ctl_w && reg_wdata[RUN_BIT];

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !stop_w) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_gnt) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R8
  busy_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && (reg_addr == IDX_COUNT) && !(mem_req && mem_we && mem_gnt))
      |=> (cnt_q == $past(cnt_q)));

  // R9
  stop_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_w) |=> !mem_req);

  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(stop_w)) |-> dma_irq);

  // R7
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_w && (cnt_q == '0)) |=> (dma_irq && !busy));
endmodule

bind qdma_channel qdma_channel_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
  .busy(busy), .cnt_q(cnt_q), .dma_irq(dma_irq)
);

// File: tb/qdma_channel_tb.sv
module qdma_channel_tb;
  localparam logic [31:0] BASE = 32'h5000_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we;
  logic [2:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         mem_req, mem_we, mem_gnt;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic         dma_irq;

  int n_chk = 0;
  int n_bad = 0;
  int gnt_div = 0;
  int cyc = 0;
  int wr_n = 0;
  logic [31:0]  wr_addr [64];
  logic [127:0] wr_data [64];

  always #5 clk = ~clk;

  qdma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .dma_irq(dma_irq)
  );

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {4{32'hC0DE_0000 | (a >> 4)}};
  endfunction

  assign mem_rdata = pat(mem_addr);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_gnt <= (gnt_div == 0) ? 1'b1 : ((cyc % gnt_div) == 0);
  end

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_gnt) begin
      wr_addr[wr_n % 64] <= mem_addr;
      wr_data[wr_n % 64] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
  end

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(3'd3, v);
      if (v[8] == 1'b0) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reg after reset", 128'(v), 128'(0));
    end
    chk("R1 mem_req after reset", 128'(mem_req), 128'(0));
    chk("R1 irq after reset", 128'(dma_irq), 128'(0));
  endtask

  task automatic t_copy(input int n, input logic [31:0] src, input logic [31:0] tgt,
                        input int div, input string tag);
    logic [31:0] v;
    int n0;
    gnt_div = div;
    wr(3'd0, 32'(n));
    wr(3'd1, src);
    wr(3'd2, tgt);
    n0 = wr_n;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h100;
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd3, v);
    chk({"R4 run bit while busy ", tag}, 128'(v[8]), 128'(1));
    wait_idle();
    rd(3'd3, v);
    chk({"R4 run bit after done ", tag}, 128'(v[8]), 128'(0));
    chk({"R2 write count ", tag}, 128'(wr_n - n0), 128'(n));
    for (int i = 0; i < n; i++) begin
      chk({"R2 dest addr ", tag}, 128'(wr_addr[(n0 + i) % 64]), 128'(BASE + tgt + 32'(16 * i)));
      chk({"R2 data ", tag}, wr_data[(n0 + i) % 64], pat(src + 32'(16 * i)));
    end
    rd(3'd0, v); chk({"R5 count zero ", tag}, 128'(v), 128'(0));
    rd(3'd1, v); chk({"R5 src advanced ", tag}, 128'(v), 128'(src + 32'(16 * n)));
    rd(3'd2, v); chk({"R5 tgt advanced ", tag}, 128'(v), 128'(tgt + 32'(16 * n)));
    rd(3'd4, v); chk({"R6 status bit2 ", tag}, 128'(v), 128'(4));
    chk({"R6 irq high ", tag}, 128'(dma_irq), 128'(1));
    wr(3'd4, 32'h4);
    rd(3'd4, v); chk({"R6 status cleared ", tag}, 128'(v), 128'(0));
    chk({"R6 irq low ", tag}, 128'(dma_irq), 128'(0));
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int n0;
    gnt_div = 0;
    wr(3'd0, 32'd0);
    n0 = wr_n;
    wr(3'd3, 32'h100);
    rd(3'd4, v); chk("R7 zero-count status", 128'(v), 128'(4));
    rd(3'd3, v); chk("R7 zero-count run bit", 128'(v[8]), 128'(0));
    chk("R7 zero-count no writes", 128'(wr_n - n0), 128'(0));
    chk("R7 zero-count no req", 128'(mem_req), 128'(0));
    wr(3'd4, 32'hFFFF);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    int n0;
    gnt_div = 5;
    wr(3'd0, 32'd4);
    wr(3'd1, 32'h200);
    wr(3'd2, 32'h0);
    n0 = wr_n;
    wr(3'd3, 32'h100);
    wr(3'd0, 32'd99);
    wr(3'd1, 32'h3F0);
    wr(3'd2, 32'h800);
    wait_idle();
    chk("R8 write count unaffected", 128'(wr_n - n0), 128'(4));
    chk("R8 last data from orig src", wr_data[(n0 + 3) % 64], pat(32'h230));
    rd(3'd1, v); chk("R8 src ignored", 128'(v), 128'(32'h240));
    rd(3'd2, v); chk("R8 tgt ignored", 128'(v), 128'(32'h40));
    rd(3'd0, v); chk("R8 count ignored", 128'(v), 128'(0));
    wr(3'd4, 32'h4);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int n0, n1;
    gnt_div = 4;
    wr(3'd0, 32'd8);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h100);
    n0 = wr_n;
    wr(3'd3, 32'h100);
    repeat (10) @(negedge clk);
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R9 run bit after stop", 128'(v[8]), 128'(0));
    n1 = wr_n;
    repeat (20) @(negedge clk);
    chk("R9 no writes after stop", 128'(wr_n), 128'(n1));
    chk("R9 req low after stop", 128'(mem_req), 128'(0));
    chk("R9 partial transfer", 128'((n1 - n0) < 8), 128'(1));
    rd(3'd0, v); chk("R9 count keeps remainder", 128'(v), 128'(8 - (n1 - n0)));
    rd(3'd4, v); chk("R9 no status on stop", 128'(v), 128'(0));
    chk("R9 irq low on stop", 128'(dma_irq), 128'(0));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_copy(3, 32'h100, 32'h40, 0, "steady");
    t_copy(2, 32'h080, 32'h300, 3, "sparse");
    t_copy(1, 32'h3F0, 32'h10, 2, "single");
    t_zero();
    t_ignore();
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule